// File: doc/BRIEF.md
# Program-Space Data Window Mapper

This block sits between a data-side requester and two memories: a data RAM and a program memory whose words are 24 bits wide. A read request carries a 16-bit effective address. If the top address bit is clear, the request goes straight to the data RAM with its address unchanged. If the top bit is set, the request falls into a 32 Kbyte window. The block turns it into a program-memory read in the lower half of program space and returns only the low 16 bits of the fetched instruction word.

An 8-bit page register, written through a plain write strobe, picks the 16K-instruction-word slice of program memory that the window shows. A windowed read costs one extra cycle, which the block imposes by holding request-ready low for one cycle.

The request side uses valid/ready. The requester raises `req_valid` with a stable address and byte flag, and holds them until a cycle in which `req_ready` is high. That cycle is the accept. The response side has no back-pressure. `rsp_valid` pulses for one cycle, one cycle after each accept, and the requester must take the data in that cycle. Both memories are assumed to return read data one clock after the read strobe.

Top module: `dwin_xlate`

## Requirements
- R1: A request with `req_addr[15]`=0 drives `ram_rd`=1 with `ram_addr` equal to `req_addr`, keeps `pm_rd`=0, and is accepted (`req_ready`=1) in the cycle it is first presented.
- R2: A request with `req_addr[15]`=1 drives `pm_rd`=1 and `pm_addr` = {0, page[6:0], req_addr[14:1], 0}. Consecutive instruction words are two address units apart.
- R3: A windowed word read returns bits [15:0] of the 24-bit program word. Bits [23:16] never reach `rsp_data`.
- R4: For a windowed request, `req_ready` is low for exactly one cycle, the first cycle it is presented. Its response arrives one cycle later than that of a pass-through read.
- R5: With `req_byte`=1, `req_addr[0]`=0 returns the low byte and `req_addr[0]`=1 returns the high byte, zero-extended in `rsp_data[7:0]` with `rsp_data[15:8]`=0. With `req_byte`=0, the full 16-bit word is returned whatever `req_addr[0]` is.
- R6: The page register resets to 0. A value written with `pg_we`=1 is used by windowed requests from the next cycle on, and not by a request issued in the same cycle as the write.
- R7: Page bit 7 has no effect: `pm_addr[22]` is always 0, so the window stays in the lower half of program space.
- R8: After reset, `rsp_valid`=0 and `pm_rd`=0 while no request is presented.
- R9: `rsp_valid` is high for exactly one cycle, in the cycle after each accept, and is low in every other cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pg_we | input | 1 | Page register write strobe |
| pg_wdata | input | 8 | Page register write value |
| req_valid | input | 1 | Read request valid |
| req_ready | output | 1 | Request accepted in this cycle |
| req_addr | input | 16 | Data effective address |
| req_byte | input | 1 | 1 = byte read, 0 = word read |
| rsp_valid | output | 1 | Response data valid (one cycle) |
| rsp_data | output | 16 | Response data |
| ram_rd | output | 1 | Data RAM read strobe |
| ram_addr | output | 16 | Data RAM address |
| ram_rdata | input | 16 | Data RAM read data, one cycle after strobe |
| pm_rd | output | 1 | Program memory read strobe |
| pm_addr | output | 23 | Program memory address |
| pm_rdata | input | 24 | Program memory word, one cycle after strobe |

## Verification
The memory strobe and address are due in the same cycle the request is first presented. Ready is due in that same cycle for a pass-through read and one cycle later for a windowed read. The response is due in the cycle after the accept, which is one cycle after presentation for pass-through reads and two cycles after for windowed reads. The bench drives inputs on the falling edge and samples on falling edges. It counts how many falling edges pass with ready low before the accept, and compares that count with the expected stall. It then checks the data exactly one cycle after the accept, and checks one cycle later that the response valid has dropped.

// File: rtl/dwin_pkg.sv
package dwin_pkg;
  typedef enum logic {
    ST_IDLE  = 1'b0,
    ST_FETCH = 1'b1
  } dwin_state_e;
endpackage

// File: rtl/dwin_page_reg.sv
module dwin_page_reg #(
  parameter int PGW = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           we,
  input  logic [PGW-1:0] wdata,
  output logic [PGW-1:0] q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  q <= '0;
    else if (we) q <= wdata;
  end
endmodule

// File: rtl/dwin_addr_map.sv
module dwin_addr_map #(
  parameter int AW  = 16,
  parameter int PGW = 8,
  localparam int PAW = PGW + AW - 1
) (
  input  logic [AW-1:0]  ea,
  input  logic [PGW-1:0] page,
  output logic           in_win,
  output logic [PAW-1:0] pm_addr
);
  // Top page bit dropped: window confined to lower half of program space.
  logic unused_page_msb;
  assign unused_page_msb = page[PGW-1];

  assign in_win  = ea[AW-1];
  assign pm_addr = {1'b0, page[PGW-2:0], ea[AW-2:1], 1'b0};
endmodule

// File: rtl/dwin_lane.sv
module dwin_lane #(
  parameter int DW = 16,
  localparam int LANES = DW / 8,
  localparam int SW = (LANES > 1) ? $clog2(LANES) : 1
) (
  input  logic [DW-1:0] word,
  input  logic          byte_mode,
  input  logic [SW-1:0] sel,
  output logic [DW-1:0] data
);
  logic [7:0] lane [LANES];

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    assign lane[i] = word[8*i +: 8];
  end

  always_comb begin
    if (byte_mode) data = {{(DW-8){1'b0}}, lane[sel]};
    else           data = word;
  end
endmodule

// File: rtl/dwin_ctrl.sv
module dwin_ctrl
  import dwin_pkg::*;
#(
  parameter int DW = 16,
  parameter int PW = 24,
  parameter int SW = 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic          in_win,
  input  logic          req_byte,
  input  logic [SW-1:0] req_sel,
  output logic          req_ready,
  output logic          ram_rd,
  output logic          pm_rd,
  input  logic [PW-1:0] pm_rdata,
  output logic          rsp_valid,
  output logic          rsp_from_pm,
  output logic [DW-1:0] held_word,
  output logic          rsp_byte,
  output logic [SW-1:0] rsp_sel
);
  dwin_state_e st, st_nxt;
  logic        accept;

  logic unused_pm_hi;
  assign unused_pm_hi = ^pm_rdata[PW-1:DW];

  always_comb begin
    st_nxt    = st;
    req_ready = 1'b0;
    ram_rd    = 1'b0;
    pm_rd     = 1'b0;
    unique case (st)
      ST_IDLE: begin
        if (req_valid) begin
          if (in_win) begin
            pm_rd  = 1'b1;
            st_nxt = ST_FETCH;
          end else begin
            ram_rd    = 1'b1;
            req_ready = 1'b1;
          end
        end
      end
      ST_FETCH: begin
        req_ready = 1'b1;
        st_nxt    = ST_IDLE;
      end
      default: st_nxt = ST_IDLE;
    endcase
  end

  assign accept = req_valid && req_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st          <= ST_IDLE;
      rsp_valid   <= 1'b0;
      rsp_from_pm <= 1'b0;
      held_word   <= '0;
      rsp_byte    <= 1'b0;
      rsp_sel     <= '0;
    end else begin
      st          <= st_nxt;
      rsp_valid   <= ram_rd || (st == ST_FETCH);
      rsp_from_pm <= (st == ST_FETCH);
      if (st == ST_FETCH) held_word <= pm_rdata[DW-1:0];
      if (accept) begin
        rsp_byte <= req_byte;
        rsp_sel  <= req_sel;
      end
    end
  end
endmodule

// File: rtl/dwin_xlate.sv
module dwin_xlate #(
  parameter int AW  = 16,
  parameter int DW  = 16,
  parameter int PW  = 24,
  parameter int PGW = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               pg_we,
  input  logic [PGW-1:0]     pg_wdata,
  input  logic               req_valid,
  output logic               req_ready,
  input  logic [AW-1:0]      req_addr,
  input  logic               req_byte,
  output logic               rsp_valid,
  output logic [DW-1:0]      rsp_data,
  output logic               ram_rd,
  output logic [AW-1:0]      ram_addr,
  input  logic [DW-1:0]      ram_rdata,
  output logic               pm_rd,
  output logic [PGW+AW-2:0]  pm_addr,
  input  logic [PW-1:0]      pm_rdata
);
  localparam int LANES = DW / 8;
  localparam int SW    = (LANES > 1) ? $clog2(LANES) : 1;

  logic [PGW-1:0] page_q;
  logic           in_win;
  logic           rsp_from_pm;
  logic [DW-1:0]  held_word;
  logic           rsp_byte;
  logic [SW-1:0]  rsp_sel;
  logic [DW-1:0]  rsp_word;

  dwin_page_reg #(.PGW(PGW)) u_page (
    .clk(clk), .rst_n(rst_n), .we(pg_we), .wdata(pg_wdata), .q(page_q)
  );

  dwin_addr_map #(.AW(AW), .PGW(PGW)) u_map (
    .ea(req_addr), .page(page_q), .in_win(in_win), .pm_addr(pm_addr)
  );

  dwin_ctrl #(.DW(DW), .PW(PW), .SW(SW)) u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .in_win(in_win), .req_byte(req_byte),
    .req_sel(req_addr[SW-1:0]), .req_ready(req_ready),
    .ram_rd(ram_rd), .pm_rd(pm_rd), .pm_rdata(pm_rdata),
    .rsp_valid(rsp_valid), .rsp_from_pm(rsp_from_pm),
    .held_word(held_word), .rsp_byte(rsp_byte), .rsp_sel(rsp_sel)
  );

  assign ram_addr = req_addr;
  assign rsp_word = rsp_from_pm ? held_word : ram_rdata;

  dwin_lane #(.DW(DW)) u_lane (
    .word(rsp_word), .byte_mode(rsp_byte), .sel(rsp_sel), .data(rsp_data)
  );
endmodule

// File: rtl/dwin_xlate_chk.sv
module dwin_xlate_chk #(
  parameter int AW  = 16,
  parameter int PGW = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              pg_we,
  input logic [PGW-1:0]    pg_wdata,
  input logic              req_valid,
  input logic              req_ready,
  input logic [AW-1:0]     req_addr,
  input logic              rsp_valid,
  input logic              ram_rd,
  input logic              pm_rd,
  input logic [PGW+AW-2:0] pm_addr
);
  localparam int PAW = PGW + AW - 1;

  // R1: lower-half requests accepted at once and never reach program memory
  p_pass_ready_r1: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !req_addr[AW-1] |-> req_ready && !pm_rd);

  // R4: a stalled windowed request is accepted the following cycle
  p_one_stall_r4: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_addr[AW-1] && !req_ready |=> req_ready);

  // R4: one program fetch per windowed access
  p_single_fetch_r4: assert property (@(posedge clk) disable iff (!rst_n)
    pm_rd |=> !pm_rd);

  // R7: program address in lower half, word aligned (R2)
  p_lower_half_r7: assert property (@(posedge clk) disable iff (!rst_n)
    pm_rd |-> !pm_addr[PAW-1] && !pm_addr[0]);

  // R2: the two memories are never read together
  p_one_target_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !(pm_rd && ram_rd));

  // R6: page written last cycle appears in the program address
  p_page_next_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $past(pg_we) && pm_rd |-> pm_addr[PAW-2:AW-1] == $past(pg_wdata[PGW-2:0]));

  // R9: response follows each accept
  p_rsp_after_accept_r9: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready |=> rsp_valid);

  // R9: no response without an accept
  p_no_spurious_rsp_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_valid && req_ready) |=> !rsp_valid);
endmodule

bind dwin_xlate dwin_xlate_chk #(.AW(AW), .PGW(PGW)) u_chk (
  .clk(clk), .rst_n(rst_n), .pg_we(pg_we), .pg_wdata(pg_wdata),
  .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
  .rsp_valid(rsp_valid), .ram_rd(ram_rd), .pm_rd(pm_rd), .pm_addr(pm_addr)
);

// File: tb/tb_dwin_xlate.sv
`timescale 1ns/1ps
module tb_dwin_xlate;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        pg_we = 1'b0;
  logic [7:0]  pg_wdata = '0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [15:0] req_addr = '0;
  logic        req_byte = 1'b0;
  logic        rsp_valid;
  logic [15:0] rsp_data;
  logic        ram_rd;
  logic [15:0] ram_addr;
  logic [15:0] ram_rdata = '0;
  logic        pm_rd;
  logic [22:0] pm_addr;
  logic [23:0] pm_rdata = '0;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;
  logic [7:0] cur_page = 8'h00;

  always #4 clk = ~clk;

  dwin_xlate dut (.*);

  // Behavioural memories, one-cycle read latency
  function automatic logic [23:0] rom_word(input logic [22:0] a);
    logic [21:0] w;
    w = a[22:1];
    return {w[7:0] ^ 8'hC3, w[15:0] ^ {w[21:16], 10'h2B5}};
  endfunction

  function automatic logic [15:0] ram_word(input logic [15:0] a);
    return (a & 16'hFFFE) ^ 16'h6E11;
  endfunction

  always @(posedge clk) begin
    if (pm_rd)  pm_rdata  <= rom_word(pm_addr);
    if (ram_rd) ram_rdata <= ram_word(ram_addr);
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr_page(input logic [7:0] v);
    @(negedge clk);
    pg_we = 1'b1; pg_wdata = v;
    @(negedge clk);
    pg_we = 1'b0;
    cur_page = v;
  endtask

  // Present a read, count stall cycles, check address, data and pulse width
  task automatic do_read(input logic [15:0] a, input logic b, input logic [7:0] pg);
    logic        win;
    logic [22:0] exp_pa;
    logic [15:0] word, exp_d;
    int          stall;
    win    = a[15];
    exp_pa = {1'b0, pg[6:0], a[14:1], 1'b0};
    word   = win ? rom_word(exp_pa)[15:0] : ram_word(a);
    if (b) exp_d = a[0] ? {8'h00, word[15:8]} : {8'h00, word[7:0]};
    else   exp_d = word;
    @(negedge clk);
    req_valid = 1'b1; req_addr = a; req_byte = b;
    #1;
    if (win) begin
      chk("R2 pm_rd/pm_addr", {8'h0, pm_rd, pm_addr}, {8'h0, 1'b1, exp_pa});
      chk("R7 pm_addr[22]", {31'h0, pm_addr[22]}, 32'h0);
    end else begin
      chk("R1 ram_rd/pm_rd/ram_addr", {14'h0, ram_rd, pm_rd, ram_addr}, {14'h0, 2'b10, a});
    end
    stall = 0;
    while (!req_ready && stall < 4) begin
      @(negedge clk);
      stall++;
    end
    chk(win ? "R4 window stall cycles" : "R1 pass stall cycles", stall, win ? 1 : 0);
    @(negedge clk);
    req_valid = 1'b0;
    chk("R9 rsp_valid after accept", {31'h0, rsp_valid}, 32'h1);
    chk(b ? "R5 byte data" : (win ? "R3 window data" : "R1 ram data"), {16'h0, rsp_data}, {16'h0, exp_d});
    @(negedge clk);
    chk("R9 rsp_valid one cycle", {31'h0, rsp_valid}, 32'h0);
  endtask

  typedef struct packed {
    logic [7:0]  page;
    logic [15:0] addr;
    logic        bsel;
  } vec_t;

  localparam int NV = 12;
  localparam vec_t VECS [NV] = '{
    '{8'h00, 16'h0000, 1'b0},
    '{8'h00, 16'h7FFE, 1'b0},
    '{8'h03, 16'h8000, 1'b0},
    '{8'h03, 16'hFFFE, 1'b0},
    '{8'h85, 16'hA123, 1'b0},
    '{8'h11, 16'h9235, 1'b1},
    '{8'h11, 16'h9234, 1'b1},
    '{8'h00, 16'h1235, 1'b1},
    '{8'h00, 16'h1234, 1'b1},
    '{8'h7F, 16'hC00A, 1'b0},
    '{8'h7F, 16'h4567, 1'b0},
    '{8'hFF, 16'hBEEF, 1'b1}
  };

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_fail++;
      n_chk++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R8: idle state after reset
    chk("R8 rsp_valid after reset", {31'h0, rsp_valid}, 32'h0);
    chk("R8 pm_rd after reset", {31'h0, pm_rd}, 32'h0);
    // R6: page resets to zero
    do_read(16'h8002, 1'b0, 8'h00);

    for (int i = 0; i < NV; i++) begin
      if (VECS[i].page != cur_page) wr_page(VECS[i].page);
      do_read(VECS[i].addr, VECS[i].bsel, cur_page);
    end

    // R6: write in the same cycle as a request uses the old page
    @(negedge clk);
    pg_we = 1'b1; pg_wdata = 8'h22;
    req_valid = 1'b1; req_addr = 16'h8010; req_byte = 1'b0;
    #1;
    chk("R6 same-cycle write uses old page", {9'h0, pm_addr}, {9'h0, 1'b0, cur_page[6:0], 14'h0008, 1'b0});
    @(negedge clk);
    pg_we = 1'b0;
    chk("R4 ready after one stall", {31'h0, req_ready}, 32'h1);
    @(negedge clk);
    req_valid = 1'b0;
    chk("R3 data with old page", {16'h0, rsp_data}, {8'h0, rom_word({1'b0, cur_page[6:0], 14'h0008, 1'b0})[15:0]});
    cur_page = 8'h22;
    // R6: the new page is used by the next request
    do_read(16'h8010, 1'b0, cur_page);

    // R5: word read at odd address returns full word
    do_read(16'hFFFF, 1'b0, cur_page);

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule